// File: doc/BRIEF.md
# Receive IQ Input Conditioning Mux

This block stands at the head of a receive down-conversion chain. It accepts signed I and Q sample pairs from a converter front end and reshapes them according to one small control word before any mixing or filtering takes place. The word can exchange the two rails, negate either output rail with saturation, and switch to real sampling. In real sampling the chosen rail is passed on as I and Q is held at zero. Real sampling serves both a plain real front end and a heterodyne one.

The sample path is a single registered stage with a valid/ready handshake on both sides. A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or the consumer is taking its contents in the same cycle. While `out_valid` is high and `out_ready` is low, the output pair is held unchanged and no new beat is accepted.

The control word is loaded through a plain write port at a fixed byte offset. A write takes effect for beats accepted after the write cycle.

Top module: `rx_iq_front_mux`

## Requirements
- R1: After reset `out_valid` is low and the control word is zero.
- R2: With the control word at zero, each output pair equals the input pair (complex sampling, no exchange, no negation).
- R3: Control bit 0 set exchanges the rails: output I takes input Q and output Q takes input I.
- R4: Control bit 3 set negates output I and control bit 2 set negates output Q. Negation saturates, so the most negative code (-2048 at 12 bits) becomes the most positive code (2047).
- R5: The exchange is applied before negation, so bits 3 and 2 act on the output rails after any exchange.
- R6: Control bit 1 set selects real sampling. Output Q is zero and output I is the rail chosen by bit 0 (input I when clear, input Q when set), negated if bit 3 is set.
- R7: An accepted beat appears at the output on the next clock with `out_valid` high. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R8: While `out_valid` is high and `out_ready` is low, `out_i` and `out_q` hold their values and `out_valid` stays high.
- R9: The control word is loaded only by a write with `cfg_addr` equal to 12. Writes to other addresses are ignored, and write data bits above bit 3 are ignored.
- R10: A beat accepted in the same cycle as a control write uses the old control word; beats accepted afterwards use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_addr | input | ADDR_W | Byte address of the write |
| cfg_wdata | input | CFG_W | Write data |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat may be accepted |
| in_i | input | SAMPLE_W | Input I sample, signed |
| in_q | input | SAMPLE_W | Input Q sample, signed |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_i | output | SAMPLE_W | Conditioned I sample, signed |
| out_q | output | SAMPLE_W | Conditioned Q sample, signed |

## Verification
The bench builds the block with 12-bit samples, as a typical converter delivers them, and keeps the default 8-bit address and 32-bit data widths. The narrow sample width puts the saturating corner (-2048 to 2047) on both rails within reach of the table vectors. The bench also combines every control bit with exchange and real sampling, and holds `out_ready` low so that the stall and hold behaviour can be checked.

// File: rtl/rxmux_pkg.sv
package rxmux_pkg;
  // Field order matches the control word bit positions 3..0
  typedef struct packed {
    logic neg_i;     // bit 3
    logic neg_q;     // bit 2
    logic real_smp;  // bit 1
    logic xchg;      // bit 0
  } mux_ctl_t;

  localparam int CTL_BITS = $bits(mux_ctl_t);
endpackage

// File: rtl/rxmux_ctl_reg.sv
module rxmux_ctl_reg
  import rxmux_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CFG_W    = 32,
  parameter int CTL_ADDR = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  wdata,
  output mux_ctl_t          ctl
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTL_ADDR);

  logic hit;
  assign hit = we && (addr == HIT_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)   ctl <= '0;
    else if (hit) ctl <= mux_ctl_t'(wdata[CTL_BITS-1:0]);
  end

  // R9: no write at the control address leaves the word unchanged
  a_r9_other_addr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == HIT_ADDR) |=> $stable(ctl));
endmodule

// File: rtl/rxmux_rail_neg.sv
module rxmux_rail_neg #(
  parameter int SAMPLE_W = 16
) (
  input  logic                       en,
  input  logic signed [SAMPLE_W-1:0] din,
  output logic signed [SAMPLE_W-1:0] dout
);
  localparam logic signed [SAMPLE_W-1:0] S_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic signed [SAMPLE_W-1:0] S_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};

  always_comb begin
    if (!en)              dout = din;
    else if (din == S_MIN) dout = S_MAX;
    else                  dout = -din;
  end

  // R4: a saturating negation never yields the most negative code
  always_comb begin
    if (en) a_r4_neg_no_min: assert (dout != S_MIN);
  end
endmodule

// File: rtl/rxmux_cond.sv
module rxmux_cond
  import rxmux_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  mux_ctl_t                   ctl,
  input  logic signed [SAMPLE_W-1:0] in_i,
  input  logic signed [SAMPLE_W-1:0] in_q,
  output logic signed [SAMPLE_W-1:0] out_i,
  output logic signed [SAMPLE_W-1:0] out_q
);
  localparam int RAILS = 2;

  logic signed [SAMPLE_W-1:0] sw   [RAILS];
  logic signed [SAMPLE_W-1:0] negd [RAILS];
  logic                       neg_en [RAILS];

  // exchange first, so negation acts on output rails
  always_comb begin
    sw[0] = ctl.xchg ? in_q : in_i;
    sw[1] = ctl.xchg ? in_i : in_q;
    neg_en[0] = ctl.neg_i;
    neg_en[1] = ctl.neg_q;
  end

  for (genvar r = 0; r < RAILS; r++) begin : g_rail
    rxmux_rail_neg #(.SAMPLE_W(SAMPLE_W)) u_neg (
      .en  (neg_en[r]),
      .din (sw[r]),
      .dout(negd[r])
    );
  end

  always_comb begin
    out_i = negd[0];
    out_q = ctl.real_smp ? '0 : negd[1];
  end
endmodule

// File: rtl/rxmux_pipe.sv
module rxmux_pipe #(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_i,
  input  logic signed [SAMPLE_W-1:0] in_q,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic signed [SAMPLE_W-1:0] out_i,
  output logic signed [SAMPLE_W-1:0] out_q
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      if (take) begin
        out_i <= in_i;
        out_q <= in_q;
      end
      if (in_ready) out_valid <= in_valid;
    end
  end

  // R7: an accepted beat is presented on the next cycle
  a_r7_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R8: a stalled beat is held
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)));
endmodule

// File: rtl/rx_iq_front_mux.sv
module rx_iq_front_mux
  import rxmux_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 8,
  parameter int CFG_W    = 32,
  parameter int CTL_ADDR = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [CFG_W-1:0]           cfg_wdata,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_i,
  input  logic signed [SAMPLE_W-1:0] in_q,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic signed [SAMPLE_W-1:0] out_i,
  output logic signed [SAMPLE_W-1:0] out_q
);
  mux_ctl_t                   ctl;
  logic signed [SAMPLE_W-1:0] c_i, c_q;

  rxmux_ctl_reg #(
    .ADDR_W(ADDR_W), .CFG_W(CFG_W), .CTL_ADDR(CTL_ADDR)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .ctl(ctl)
  );

  rxmux_cond #(.SAMPLE_W(SAMPLE_W)) u_cond (
    .ctl(ctl), .in_i(in_i), .in_q(in_q), .out_i(c_i), .out_q(c_q)
  );

  rxmux_pipe #(.SAMPLE_W(SAMPLE_W)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(c_i), .in_q(c_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  // R1: output register empty in the cycle after reset
  a_r1_reset_empty: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/rx_iq_front_mux_test.sv
module rx_iq_front_mux_test;
  localparam int SW = 12;
  localparam int NV = 12;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [7:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic in_valid = 0, out_ready = 1;
  logic signed [SW-1:0] in_i = 0, in_q = 0;
  logic in_ready, out_valid;
  logic signed [SW-1:0] out_i, out_q;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  rx_iq_front_mux #(.SAMPLE_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_ready(out_ready),
    .out_i(out_i), .out_q(out_q)
  );

  // control bits: 0 exchange, 1 real, 2 negate Q, 3 negate I
  localparam logic [3:0] V_CTL [NV] = '{4'h0, 4'h1, 4'h8, 4'h4, 4'h8, 4'h4,
                                        4'h9, 4'h2, 4'h3, 4'hA, 4'hF, 4'hC};
  localparam logic signed [SW-1:0] V_I [NV] = '{100, 100, 100, 100, -2048, 0,
                                               300, 300, 300, 300, 300, 2047};
  localparam logic signed [SW-1:0] V_Q [NV] = '{-200, -200, -200, -200, 5, -2048,
                                               7, 7, 7, 7, 7, -2048};
  localparam logic signed [SW-1:0] E_I [NV] = '{100, -200, -100, 100, 2047, 0,
                                               -7, 300, 7, -300, -7, -2047};
  localparam logic signed [SW-1:0] E_Q [NV] = '{-200, 100, -200, 200, 5, 2047,
                                               300, 0, 0, 0, 0, 2047};
  localparam string V_REQ [NV] = '{"R2", "R3", "R4", "R4", "R4", "R4",
                                   "R5", "R6", "R6", "R6", "R5", "R4"};

  task automatic chk(input string req, input logic signed [SW-1:0] ai, aq, ei, eq);
    total++;
    if (ai !== ei || aq !== eq) begin
      bad++;
      $display("FAIL %s: got i=%0d q=%0d expected i=%0d q=%0d", req, ai, aq, ei, eq);
    end
  endtask

  task automatic chk_bit(input string req, input logic a, e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", req, a, e);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk); cfg_we = 0;
  endtask

  // present one beat, sample result at following negedge
  task automatic send(input logic signed [SW-1:0] i, q);
    @(negedge clk); in_valid = 1; in_i = i; in_q = q;
    @(posedge clk); @(negedge clk); in_valid = 0;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_bit("R1 out_valid in reset", out_valid, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk_bit("R1 out_valid after reset", out_valid, 1'b0);
    chk_bit("R7 ready when empty", in_ready, 1'b1);
    send(12, -34);
    chk("R1 zero control after reset", out_i, out_q, 12, -34);
    chk_bit("R7 valid after accept", out_valid, 1'b1);
    @(negedge clk);
    chk_bit("R7 valid drops with no beat", out_valid, 1'b0);

    for (int k = 0; k < NV; k++) begin
      wr(8'd12, {28'h0, V_CTL[k]});
      send(V_I[k], V_Q[k]);
      chk(V_REQ[k], out_i, out_q, E_I[k], E_Q[k]);
    end

    // R9: other address ignored
    wr(8'd12, 32'h0);
    wr(8'd8, 32'h1);
    send(5, 6);
    chk("R9 wrong address ignored", out_i, out_q, 5, 6);
    // R9: upper data bits ignored
    wr(8'd12, 32'hFFFF_FFF0);
    send(5, 6);
    chk("R9 upper bits ignored", out_i, out_q, 5, 6);

    // R10: write and beat in the same cycle
    @(negedge clk);
    cfg_we = 1; cfg_addr = 8'd12; cfg_wdata = 32'h1;
    in_valid = 1; in_i = 40; in_q = 50;
    @(posedge clk); @(negedge clk);
    cfg_we = 0; in_valid = 0;
    chk("R10 same-cycle beat uses old word", out_i, out_q, 40, 50);
    send(40, 50);
    chk("R10 later beat uses new word", out_i, out_q, 50, 40);

    // R8: stall
    wr(8'd12, 32'h0);
    out_ready = 0;
    send(1, 2);
    chk_bit("R7 not ready when full and stalled", in_ready, 1'b0);
    in_valid = 1; in_i = 3; in_q = 4;
    @(posedge clk); @(negedge clk);
    chk("R8 held while stalled", out_i, out_q, 1, 2);
    chk_bit("R8 valid held", out_valid, 1'b1);
    out_ready = 1;
    #0.1;
    chk_bit("R7 ready when consumer takes", in_ready, 1'b1);
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    chk("R7 next beat after release", out_i, out_q, 3, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule